// File: doc/BRIEF.md
# Configuration Access Sequencer

This block turns a single configuration-space request (device, function, register offset, access size of one, two or four bytes, and write data) into one or two word cycles on a simple backend port. It forms a type-0 configuration word address in which the target device is chosen by a single set bit, and it rejects requests the address window cannot reach. A narrow write becomes a word read, a byte-lane merge and a word write. While the sequence runs, the block drives a configuration-mode select so that the backend issues configuration cycles instead of memory cycles. It drops the select again when it finishes.

The backend answers each cycle with an acknowledge and may raise an abort indication at any time. The block keeps a sticky abort flag. It clears that flag before it starts, tests it after the read and again after the write, and turns a set flag into a not-found result. The requester sees a busy level and then a one-cycle completion strobe. The strobe carries a not-found status and the read data, already shifted down and masked to the requested lane.

Top module: `cfg_access_seq`

## Requirements
- R1: The word address on the backend is the OR of a single set bit at position 13 plus the device number, the function number shifted left by 8, and the register offset with its two low bits forced to zero.
- R2: A request with a device number above 18, or whose address would be 0x100000 or higher, completes as not-found one cycle after acceptance without any backend cycle.
- R3: A request to device 3 completes as not-found without a backend cycle unless the local-access input is set with it, in which case it proceeds normally.
- R4: The read data returned is the fetched word shifted right by 8 times the offset's low two bits and masked to the low 8, 16 or 32 bits for sizes 1, 2 or 4.
- R5: A write performs a backend read of the word, then a backend write of that word with only the addressed byte lanes replaced by the low bytes of the write data; lanes beyond bit 31 are dropped.
- R6: An abort indication seen before a request's first backend cycle is cleared and does not affect that request.
- R7: An abort seen up to and including the read acknowledge makes the request complete as not-found with no write cycle.
- R8: An abort seen up to and including the write acknowledge makes the request complete as not-found after the write cycle.
- R9: The configuration-mode select is high from the cycle before the first backend cycle until the last check, is high whenever a backend cycle is requested, and is low when idle and in the completion cycle.
- R10: Busy rises on the cycle after a request is accepted and stays high through the one-cycle completion strobe. A request presented while busy is ignored.
- R11: A not-found result returns all ones as data. A successful write returns zero. Outside the completion strobe the data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLocal | input | 1 | Permits access to the host's own slot |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOffset | input | 8 | Register byte offset |
| reqSize | input | 3 | Access size in bytes (1, 2 or 4) |
| reqWdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| doneValid | output | 1 | One-cycle completion strobe |
| doneNotFound | output | 1 | Completion status: device not found |
| doneRdata | output | 32 | Completion data |
| cfgMode | output | 1 | Selects configuration cycles on the backend |
| busReq | output | 1 | Backend cycle request, held until acknowledge |
| busWrite | output | 1 | Backend cycle is a write |
| busAddr | output | 20 | Backend word address |
| busWdata | output | 32 | Backend write word |
| busAck | input | 1 | Backend cycle acknowledge |
| busRdata | input | 32 | Backend read word, valid with acknowledge |
| busAbort | input | 1 | Backend abort indication |

## Verification
The bench aims at lane placement at the top of the word, such as a one-byte read at offset 3 and a two-byte write at offset 2. A wrong shift or mask there returns the wrong byte or corrupts neighbouring lanes, and a later full-word read exposes that. It places aborts on the read acknowledge, on the write acknowledge and while idle. A design that skips the start-of-request clear fails the idle case. One that checks only once either writes after a read abort or reports success after a write abort. Refusals cover device 7 (out of the window), device 19 and the host slot with and without local access; a design that lets any of these onto the bus shows a backend request the reference does not expect. A second request held high during a busy sequence must leave the addresses and data of the running request intact.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    StIdle,
    StPrep,
    StRead,
    StReadChk,
    StWrite,
    StWriteChk,
    StFinish
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture the incoming request
    logic captureWord;  // capture the backend read word
    logic clrAbort;     // clear the sticky abort flag
  } dpStrobe_t;

endpackage

// File: rtl/cfg_seq_datapath.sv
module cfg_seq_datapath
  import cfg_seq_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int DevBits   = 5,
  parameter int FuncBits  = 3,
  parameter int OffBits   = 8,
  parameter int SizeBits  = 3,
  parameter int SelBase   = 13,
  parameter int MaxDev    = 18,
  parameter int HostSlot  = 3,
  parameter int SpaceBits = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 reqWrite,
  input  logic                 reqLocal,
  input  logic [DevBits-1:0]   reqDev,
  input  logic [FuncBits-1:0]  reqFunc,
  input  logic [OffBits-1:0]   reqOffset,
  input  logic [SizeBits-1:0]  reqSize,
  input  logic [DataW-1:0]     reqWdata,
  input  logic                 busAbort,
  input  logic [DataW-1:0]     busRdata,
  output logic                 reqRefused,
  output logic                 isWrite,
  output logic                 abortFlag,
  output logic [SpaceBits-1:0] busAddr,
  output logic [DataW-1:0]     busWdata,
  output logic [DataW-1:0]     laneData
);

  localparam int FullW     = SelBase + MaxDev + 1;
  localparam int MaxBytes  = DataW / 8;
  localparam int LaneBits  = $clog2(MaxBytes);
  localparam int ShiftBits = $clog2(DataW);

  // Request address decode
  logic [FullW-1:0] selBit;
  logic [FullW-1:0] reqAddr;
  logic             devTooHigh;
  logic             outOfSpace;
  logic             hostHit;

  always_comb begin
    selBit = '0;
    for (int d = 0; d <= MaxDev; d++) begin
      if (reqDev == DevBits'(d)) selBit[SelBase + d] = 1'b1;
    end
  end

  assign reqAddr    = selBit
                    | (FullW'(reqFunc) << OffBits)
                    | FullW'({reqOffset[OffBits-1:LaneBits], {LaneBits{1'b0}}});
  assign devTooHigh = (int'(reqDev) > MaxDev);
  assign outOfSpace = |reqAddr[FullW-1:SpaceBits];
  assign hostHit    = (reqDev == DevBits'(HostSlot)) && !reqLocal;
  assign reqRefused = devTooHigh || outOfSpace || hostHit;

  // Latched request
  logic [SpaceBits-1:0] addrR;
  logic [LaneBits-1:0]  laneR;
  logic [SizeBits-1:0]  sizeR;
  logic                 writeR;
  logic [DataW-1:0]     wdataR;
  logic [DataW-1:0]     wordR;
  logic                 abortR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR  <= '0;
      laneR  <= '0;
      sizeR  <= '0;
      writeR <= 1'b0;
      wdataR <= '0;
    end else if (strobe.latchReq) begin
      addrR  <= reqAddr[SpaceBits-1:0];
      laneR  <= reqOffset[LaneBits-1:0];
      sizeR  <= reqSize;
      writeR <= reqWrite;
      wdataR <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   wordR <= '0;
    else if (strobe.captureWord) wordR <= busRdata;
  end

  // Sticky abort flag; a clear wins over a same-cycle abort
  always_ff @(posedge clk) begin
    if (!rstN)                abortR <= 1'b0;
    else if (strobe.clrAbort) abortR <= 1'b0;
    else                      abortR <= abortR | busAbort;
  end

  // Lane mask and merge
  logic [DataW-1:0]     laneMask;
  logic [ShiftBits-1:0] byteShift;

  always_comb begin
    if (sizeR == '0 || int'(sizeR) > MaxBytes) laneMask = '1;
    else laneMask = {DataW{1'b1}} >> (8 * (MaxBytes - int'(sizeR)));
  end

  assign byteShift = {laneR, 3'b000};
  assign busWdata  = (wordR & ~(laneMask << byteShift))
                   | ((wdataR & laneMask) << byteShift);
  assign laneData  = (wordR >> byteShift) & laneMask;
  assign busAddr   = addrR;
  assign isWrite   = writeR;
  assign abortFlag = abortR;

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !strobe.clrAbort) |=> abortFlag); // R6

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqRefused,
  input  logic      isWrite,
  input  logic      abortFlag,
  input  logic      busAck,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      busWrite,
  output logic      cfgMode,
  output logic      busy,
  output logic      doneValid,
  output logic      doneNotFound
);

  seqState_t state, stateNext;
  logic      notFoundR, notFoundNext;
  logic      accept;

  assign accept = (state == StIdle) && reqValid;

  always_comb begin
    stateNext    = state;
    notFoundNext = notFoundR;
    unique case (state)
      StIdle: begin
        if (reqValid) begin
          notFoundNext = reqRefused;
          stateNext    = reqRefused ? StFinish : StPrep;
        end
      end
      StPrep:   stateNext = StRead;
      StRead:   if (busAck) stateNext = StReadChk;
      StReadChk: begin
        if (abortFlag) begin
          notFoundNext = 1'b1;
          stateNext    = StFinish;
        end else begin
          stateNext = isWrite ? StWrite : StFinish;
        end
      end
      StWrite:  if (busAck) stateNext = StWriteChk;
      StWriteChk: begin
        if (abortFlag) notFoundNext = 1'b1;
        stateNext = StFinish;
      end
      StFinish: stateNext = StIdle;
      default:  stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= StIdle;
      notFoundR <= 1'b0;
    end else begin
      state     <= stateNext;
      notFoundR <= notFoundNext;
    end
  end

  always_comb begin
    strobe.latchReq    = accept;
    strobe.captureWord = (state == StRead) && busAck;
    strobe.clrAbort    = (state == StPrep)
                      || (((state == StReadChk) || (state == StWriteChk)) && abortFlag);
  end

  assign busReq       = (state == StRead) || (state == StWrite);
  assign busWrite     = (state == StWrite);
  assign cfgMode      = (state != StIdle) && (state != StFinish);
  assign busy         = (state != StIdle);
  assign doneValid    = (state == StFinish);
  assign doneNotFound = doneValid && notFoundR;

  AST_BUS_IN_CFG: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> cfgMode); // R9

  AST_IDLE_MEM_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || doneValid) |-> !cfgMode); // R9

  AST_REFUSED_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqRefused) |=> (doneValid && doneNotFound && !busReq)); // R2

  AST_RD_ABORT_NF: assert property (@(posedge clk) disable iff (!rstN)
    ((state == StReadChk) && abortFlag) |=> (doneValid && doneNotFound)); // R7

  AST_WR_ABORT_NF: assert property (@(posedge clk) disable iff (!rstN)
    ((state == StWriteChk) && abortFlag) |=> (doneValid && doneNotFound)); // R8

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWrite) |-> $past(state == StReadChk)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy)); // R10

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_seq_pkg::*;
#(
  parameter int DataW     = 32,
  parameter int DevBits   = 5,
  parameter int FuncBits  = 3,
  parameter int OffBits   = 8,
  parameter int SizeBits  = 3,
  parameter int SelBase   = 13,
  parameter int MaxDev    = 18,
  parameter int HostSlot  = 3,
  parameter int SpaceBits = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqLocal,
  input  logic [DevBits-1:0]   reqDev,
  input  logic [FuncBits-1:0]  reqFunc,
  input  logic [OffBits-1:0]   reqOffset,
  input  logic [SizeBits-1:0]  reqSize,
  input  logic [DataW-1:0]     reqWdata,
  output logic                 busy,
  output logic                 doneValid,
  output logic                 doneNotFound,
  output logic [DataW-1:0]     doneRdata,
  output logic                 cfgMode,
  output logic                 busReq,
  output logic                 busWrite,
  output logic [SpaceBits-1:0] busAddr,
  output logic [DataW-1:0]     busWdata,
  input  logic                 busAck,
  input  logic [DataW-1:0]     busRdata,
  input  logic                 busAbort
);

  dpStrobe_t        strobe;
  logic             reqRefused;
  logic             isWrite;
  logic             abortFlag;
  logic [DataW-1:0] laneData;

  cfg_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqRefused   (reqRefused),
    .isWrite      (isWrite),
    .abortFlag    (abortFlag),
    .busAck       (busAck),
    .strobe       (strobe),
    .busReq       (busReq),
    .busWrite     (busWrite),
    .cfgMode      (cfgMode),
    .busy         (busy),
    .doneValid    (doneValid),
    .doneNotFound (doneNotFound)
  );

  cfg_seq_datapath #(
    .DataW     (DataW),
    .DevBits   (DevBits),
    .FuncBits  (FuncBits),
    .OffBits   (OffBits),
    .SizeBits  (SizeBits),
    .SelBase   (SelBase),
    .MaxDev    (MaxDev),
    .HostSlot  (HostSlot),
    .SpaceBits (SpaceBits)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqLocal   (reqLocal),
    .reqDev     (reqDev),
    .reqFunc    (reqFunc),
    .reqOffset  (reqOffset),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .busAbort   (busAbort),
    .busRdata   (busRdata),
    .reqRefused (reqRefused),
    .isWrite    (isWrite),
    .abortFlag  (abortFlag),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .laneData   (laneData)
  );

  always_comb begin
    if (!doneValid)        doneRdata = '0;
    else if (doneNotFound) doneRdata = '1;
    else if (isWrite)      doneRdata = '0;
    else                   doneRdata = laneData;
  end

  AST_NF_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    doneNotFound |-> (doneRdata == '1)); // R11

endmodule

// File: tb/cfg_access_seq_test.sv
`timescale 1ns/1ps
module cfg_access_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqLocal = 1'b0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [7:0]  reqOffset = '0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        busy, doneValid, doneNotFound, cfgMode, busReq, busWrite;
  logic [31:0] doneRdata, busWdata;
  logic [19:0] busAddr;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;
  logic        ackAbort = 1'b0, idleAbort = 1'b0;
  logic        busAbort;

  assign busAbort = ackAbort | idleAbort;

  always #10 clk = ~clk;  // 50 MHz

  cfg_access_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLocal(reqLocal), .reqDev(reqDev), .reqFunc(reqFunc),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .busy(busy), .doneValid(doneValid), .doneNotFound(doneNotFound),
    .doneRdata(doneRdata), .cfgMode(cfgMode), .busReq(busReq),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .busAbort(busAbort)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // Backend memory and responder
  logic [31:0] mem [int unsigned];
  int ackLat = 0;
  int waitCnt = 0;
  int abortCountdown = 0;

  always @(negedge clk) begin
    if (busAck) begin
      busAck   = 1'b0;
      ackAbort = 1'b0;
      waitCnt  = 0;
    end else if (busReq) begin
      if (waitCnt >= ackLat) begin
        busAck = 1'b1;
        if (busWrite) mem[int'(busAddr)] = busWdata;
        else busRdata = mem.exists(int'(busAddr)) ? mem[int'(busAddr)] : 32'h0;
        if (abortCountdown == 1) ackAbort = 1'b1;
        if (abortCountdown > 0) abortCountdown--;
      end else begin
        waitCnt++;
      end
    end
  end

  // Reference model helpers
  function automatic longint modelAddr(input int dev, input int fn, input int off);
    return (longint'(1) << (13 + dev)) | longint'(fn * 256) | longint'(off - (off % 4));
  endfunction

  function automatic bit modelRefuse(input int dev, input bit lc, input int fn, input int off);
    if (dev > 18) return 1'b1;
    if (modelAddr(dev, fn, off) >= 64'h100000) return 1'b1;
    if (dev == 3 && !lc) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] modelExtract(input logic [31:0] w, input int off, input int sz);
    logic [31:0] r = '0;
    for (int b = 0; b < sz; b++) begin
      int src = (off % 4) + b;
      if (src < 4) r[8*b +: 8] = w[8*src +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] modelMerge(input logic [31:0] w, input logic [31:0] d,
                                             input int off, input int sz);
    logic [31:0] r = w;
    for (int b = 0; b < sz; b++) begin
      int dst = (off % 4) + b;
      if (dst < 4) r[8*dst +: 8] = d[8*b +: 8];
    end
    return r;
  endfunction

  // Reference model state: 0 idle, 1 select, 2 read, 3 read check,
  // 4 write, 5 write check, 6 completion
  int          mPhase = 0;
  bit          mAbort = 1'b0, mNf = 1'b0, mWrite = 1'b0, clearNow;
  int          mOff = 0, mSize = 0;
  longint      mAddr = 0;
  logic [31:0] mWord = '0, mWdata = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0;
      mAbort = 1'b0;
      mNf    = 1'b0;
    end else begin
      clearNow = (mPhase == 1) || ((mPhase == 3 || mPhase == 5) && mAbort);
      case (mPhase)
        0: if (reqValid) begin
          mWrite = reqWrite;
          mOff   = int'(reqOffset);
          mSize  = int'(reqSize);
          mWdata = reqWdata;
          mAddr  = modelAddr(int'(reqDev), int'(reqFunc), int'(reqOffset));
          if (modelRefuse(int'(reqDev), reqLocal, int'(reqFunc), int'(reqOffset))) begin
            mNf = 1'b1; mPhase = 6;
          end else begin
            mNf = 1'b0; mPhase = 1;
          end
        end
        1: mPhase = 2;
        2: if (busAck) begin mWord = busRdata; mPhase = 3; end
        3: if (mAbort) begin mNf = 1'b1; mPhase = 6; end
           else mPhase = mWrite ? 4 : 6;
        4: if (busAck) mPhase = 5;
        5: begin if (mAbort) mNf = 1'b1; mPhase = 6; end
        default: mPhase = 0;
      endcase
      mAbort = clearNow ? 1'b0 : (mAbort | busAbort);
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !summaryDone) begin
      logic [31:0] expData;
      chk("R10 busy", busy, (mPhase != 0));
      chk("R9 cfgMode", cfgMode, (mPhase >= 1 && mPhase <= 5));
      chk("R2 busReq", busReq, (mPhase == 2 || mPhase == 4));
      chk("R5 busWrite", busWrite, (mPhase == 4));
      chk("R10 doneValid", doneValid, (mPhase == 6));
      if (mPhase == 2 || mPhase == 4) chk("R1 busAddr", busAddr, mAddr[31:0]);
      if (mPhase == 4) chk("R5 busWdata", busWdata, modelMerge(mWord, mWdata, mOff, mSize));
      if (mPhase == 6) begin
        if (mNf) expData = 32'hFFFF_FFFF;
        else if (mWrite) expData = 32'h0;
        else expData = modelExtract(mWord, mOff, mSize);
        chk("R7 doneNotFound", doneNotFound, mNf);
        chk("R4 doneRdata", doneRdata, expData);
      end else begin
        chk("R11 idle data", doneRdata, 32'h0);
      end
    end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  task automatic doReq(input bit wr, input bit lc, input int dev, input int fn,
                       input int off, input int sz, input logic [31:0] wd,
                       input bit expNf, input logic [31:0] expData, input string tag);
    @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqLocal  = lc;
    reqDev    = 5'(dev);
    reqFunc   = 3'(fn);
    reqOffset = 8'(off);
    reqSize   = 3'(sz);
    reqWdata  = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneValid) @(negedge clk);
    chk({tag, " status"}, doneNotFound, expNf);
    chk({tag, " data"}, doneRdata, expData);
    @(negedge clk);
  endtask

  initial begin
    mem[32'h4000] = 32'h1234_5678;
    mem[32'h8110] = 32'hA1B2_C3D4;
    mem[32'h27FC] = 32'hCAFE_F00D;
    mem[32'h10000] = 32'h00FF_1234;

    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 1'b0);
    chk("R9 reset cfgMode", cfgMode, 1'b0);
    chk("R2 reset busReq", busReq, 1'b0);
    chk("R10 reset doneValid", doneValid, 1'b0);
    rstN = 1'b1;

    // R1 R4 reads with varied lanes and latencies
    ackLat = 0;
    doReq(0, 0, 1, 0, 8'h00, 4, 0, 0, 32'h1234_5678, "R1 R4 word read dev1");
    ackLat = 2;
    doReq(0, 0, 2, 1, 8'h13, 1, 0, 0, 32'h0000_00A1, "R4 byte read lane3");
    doReq(0, 0, 2, 1, 8'h12, 2, 0, 0, 32'h0000_A1B2, "R4 half read lane2");
    ackLat = 1;
    doReq(0, 0, 0, 7, 8'hFD, 1, 0, 0, 32'h0000_00F0, "R1 R4 byte read func7");

    // R5 R11 read-modify-write
    doReq(1, 0, 1, 0, 8'h02, 1, 32'hFFFF_FFEE, 0, 32'h0, "R5 R11 byte write");
    doReq(0, 0, 1, 0, 8'h00, 4, 0, 0, 32'h12EE_5678, "R5 readback byte write");
    ackLat = 3;
    doReq(1, 0, 2, 1, 8'h10, 2, 32'h0000_BEEF, 0, 32'h0, "R5 half write");
    doReq(0, 0, 2, 1, 8'h10, 4, 0, 0, 32'hA1B2_BEEF, "R5 readback half write");

    // R2 R3 refusals
    doReq(0, 0, 7, 0, 8'h00, 4, 0, 1, 32'hFFFF_FFFF, "R2 R11 dev7 out of window");
    doReq(1, 0, 19, 0, 8'h00, 4, 32'h1, 1, 32'hFFFF_FFFF, "R2 dev19 write");
    doReq(0, 0, 3, 0, 8'h00, 4, 0, 1, 32'hFFFF_FFFF, "R3 host slot refused");
    ackLat = 0;
    doReq(0, 1, 3, 0, 8'h00, 4, 0, 0, 32'h00FF_1234, "R3 host slot local");

    // R6 stale abort while idle
    @(negedge clk); idleAbort = 1'b1;
    @(negedge clk); idleAbort = 1'b0;
    doReq(0, 0, 1, 0, 8'h00, 4, 0, 0, 32'h12EE_5678, "R6 stale abort ignored");

    // R7 abort on read ack, write suppressed
    abortCountdown = 1;
    doReq(1, 0, 0, 7, 8'hFC, 4, 32'h1111_1111, 1, 32'hFFFF_FFFF, "R7 abort on read of write");
    doReq(0, 0, 0, 7, 8'hFC, 4, 0, 0, 32'hCAFE_F00D, "R7 no write after abort");
    abortCountdown = 1;
    doReq(0, 0, 2, 1, 8'h10, 4, 0, 1, 32'hFFFF_FFFF, "R7 abort on plain read");

    // R8 abort on write ack
    abortCountdown = 2;
    doReq(1, 0, 0, 7, 8'hFC, 1, 32'h0000_0055, 1, 32'hFFFF_FFFF, "R8 abort on write");
    doReq(0, 0, 0, 7, 8'hFC, 4, 0, 0, 32'hCAFE_F055, "R8 write still landed");

    // R10 request while busy ignored
    ackLat = 3;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqLocal = 1'b0;
    reqDev = 5'd1; reqFunc = 3'd0; reqOffset = 8'h00; reqSize = 3'd4;
    @(negedge clk);
    reqDev = 5'd2; reqFunc = 3'd1; reqOffset = 8'h11; reqSize = 3'd1;
    reqWrite = 1'b1; reqWdata = 32'h77;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    while (!doneValid) @(negedge clk);
    chk("R10 busy ignore status", doneNotFound, 1'b0);
    chk("R10 busy ignore data", doneRdata, 32'h12EE_5678);
    repeat (3) @(negedge clk);
    chk("R10 no second request", busy, 1'b0);
    doReq(0, 0, 2, 1, 8'h10, 4, 0, 0, 32'hA1B2_BEEF, "R10 ignored write left memory");

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule